// File: doc/BRIEF.md
# Processor Low-Power State Controller

This block is a synchronous sequencer that moves a processor core between its run and power-saving states: Normal, Halt, Extended Halt, Stop-Grant, the transient snoop-service state reached from Stop-Grant, and Sleep. Two further transient states cover the voltage/frequency step down into Extended Halt and the step back up out of it. Clock gating, the PLL and the regulator are outside the block. Only their handshakes appear here: a lower request, a restore request and a single transition-done flag.

The platform raises a stop-clock request to park the core in Stop-Grant. While the core is parked, bus snoops and interrupts take a short detour through the snoop-service state and then return to Stop-Grant. A sleep request is honoured only in Stop-Grant. A sleep request in any other state is a protocol violation, and so is a snoop or interrupt that arrives while the core sleeps. Each violation sets a sticky flag and leaves the state unchanged. A halt strobe from the core enters plain Halt, or, when the extended-halt enable is set, steps the voltage down and then enters Extended Halt.

The state code is brought out on a 3-bit port so that neighbouring power logic can decode it.

Top module: `lp_state_ctrl`

## Requirements
- R1: The active-low reset is synchronous. While `rst_n` is low at a clock edge, the next state is Normal and the interrupt-latched and violation flags clear. State codes on `state_o`: Normal=0, Halt=1, ExtHalt-entry=2, Extended Halt=3, ExtHalt-exit=4, Stop-Grant=5, Snoop-service=6, Sleep=7.
- R2: In Normal, `stopclk_req` moves to Stop-Grant and takes priority over `halt_stb`. Otherwise `halt_stb` moves to ExtHalt-entry when `c1e_en` is 1 and to Halt when it is 0.
- R3: In ExtHalt-entry, `vf_lower_o` is 1 and the state holds until `vf_done` is 1, then moves to Extended Halt. Extended Halt is reached from no other state.
- R4: `intr_pulse` in Halt returns to Normal. `intr_pulse` in Extended Halt moves to ExtHalt-exit, where `vf_restore_o` is 1 until `vf_done` moves the state to Normal.
- R5: In Stop-Grant, `snoop_start` or `intr_pulse` moves to Snoop-service. The state stays there while a started snoop has not been reported by `snoop_done`, and returns to Stop-Grant once nothing is pending. An interrupt-only entry therefore lasts one cycle.
- R6: In Stop-Grant, `sleep_req` enters Sleep even if asserted for one cycle, with priority over snoop and interrupt. In Sleep, a low `sleep_req` returns to Stop-Grant. In Stop-Grant, a low `stopclk_req` returns to Normal.
- R7: `sleep_req` in any state other than Stop-Grant or Sleep changes nothing about the state and sets `violation_o`. The flag stays set until reset.
- R8: In Sleep, `snoop_resp_o` is 0. `snoop_start` or `intr_pulse` sets `violation_o`, does not change the state and does not set `intr_latched_o`. In all other states `snoop_resp_o` is 1.
- R9: Reset asserted in Sleep reaches Normal at the next edge without passing through Stop-Grant.
- R10: `intr_pulse` seen in Halt, Extended Halt, Stop-Grant or Snoop-service sets `intr_latched_o`. The flag clears at the edge after any cycle spent in Normal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stopclk_req | input | 1 | Stop-clock request level |
| sleep_req | input | 1 | Sleep request level |
| snoop_start | input | 1 | Bus snoop begins (strobe) |
| snoop_done | input | 1 | Snoop serviced by any agent (strobe) |
| intr_pulse | input | 1 | Interrupt event (strobe) |
| halt_stb | input | 1 | Core executed a halt (strobe) |
| c1e_en | input | 1 | Extended-halt enable |
| vf_done | input | 1 | Voltage/frequency step finished |
| state_o | output | 3 | Current state code (see R1) |
| snoop_resp_o | output | 1 | Core can answer snoops |
| intr_latched_o | output | 1 | An interrupt was captured |
| vf_lower_o | output | 1 | Request voltage/frequency step down |
| vf_restore_o | output | 1 | Request voltage/frequency step up |
| violation_o | output | 1 | Sticky protocol-violation flag |

## Verification
On every cycle, the assertions check that Extended Halt and Sleep are entered only from their permitted predecessors. They also check that Sleep holds against snoops and interrupts, that the violation flag is sticky and is raised by a misplaced sleep request, that Snoop-service returns only to Stop-Grant, and that the interrupt flag clears after Normal. Other behaviours appear only in the bench's scenarios: the exact exit cycle of a snoop detour, the one-cycle sleep pulse, the halt/stop-clock priority, and reset pulling Sleep straight to Normal. For these the lockstep model and the labelled checks compare the exact cycle of each transition.

// File: rtl/lp_pkg.sv
package lp_pkg;

  localparam int unsigned ST_W = 3;

  typedef enum logic [ST_W-1:0] {
    ST_NORMAL  = 3'd0,
    ST_HALT    = 3'd1,
    ST_XH_DOWN = 3'd2,
    ST_XHALT   = 3'd3,
    ST_XH_UP   = 3'd4,
    ST_STOPG   = 3'd5,
    ST_SNOOP   = 3'd6,
    ST_SLEEP   = 3'd7
  } lp_state_e;

  // States in which an interrupt strobe is captured (R10)
  function automatic logic fn_takes_intr(input lp_state_e st);
    return (st == ST_HALT) || (st == ST_XHALT) ||
           (st == ST_STOPG) || (st == ST_SNOOP);
  endfunction

  // States in which a sleep request is legal (R6/R7)
  function automatic logic fn_sleep_legal(input lp_state_e st);
    return (st == ST_STOPG) || (st == ST_SLEEP);
  endfunction

  // Halt target chosen by the extended-halt enable (R2)
  function automatic lp_state_e fn_halt_target(input logic c1e);
    return c1e ? ST_XH_DOWN : ST_HALT;
  endfunction

  // Pending-snoop bookkeeping for the detour state (R5)
  function automatic logic fn_pend_next(input lp_state_e st,
                                        input logic pend,
                                        input logic start,
                                        input logic done,
                                        input logic sleep);
    logic r;
    case (st)
      ST_STOPG: r = start & ~sleep;
      ST_SNOOP: r = (pend & ~done) | start;
      default:  r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/lp_event_flags.sv
module lp_event_flags
  import lp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  lp_state_e state_q,
  input  logic      sleep_req,
  input  logic      snoop_start,
  input  logic      snoop_done,
  input  logic      intr_pulse,
  output logic      pend_d,
  output logic      intr_latched_q,
  output logic      violation_q,
  output logic      ev_bad_sleep,
  output logic      ev_bad_wake
);

  logic pend_q;
  logic intr_take;
  logic viol_d;
  logic intr_d;

  // Event wires kept separate for assertions
  assign ev_bad_sleep = sleep_req & ~fn_sleep_legal(state_q);
  assign ev_bad_wake  = (state_q == ST_SLEEP) & (snoop_start | intr_pulse);
  assign intr_take    = intr_pulse & fn_takes_intr(state_q);

  assign pend_d = fn_pend_next(state_q, pend_q, snoop_start, snoop_done, sleep_req);
  assign viol_d = violation_q | ev_bad_sleep | ev_bad_wake;
  assign intr_d = (state_q == ST_NORMAL) ? 1'b0 : (intr_latched_q | intr_take);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q         <= 1'b0;
      intr_latched_q <= 1'b0;
      violation_q    <= 1'b0;
    end else begin
      pend_q         <= pend_d;
      intr_latched_q <= intr_d;
      violation_q    <= viol_d;
    end
  end

  p_viol_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    violation_q |=> violation_q);

  p_bad_sleep_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bad_sleep |=> violation_q);

  p_sleep_no_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLEEP) && !intr_latched_q |=> !intr_latched_q);

  p_intr_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_NORMAL) |=> !intr_latched_q);

endmodule

// File: rtl/lp_next_state.sv
module lp_next_state
  import lp_pkg::*;
(
  input  lp_state_e state_q,
  input  logic      stopclk_req,
  input  logic      sleep_req,
  input  logic      snoop_start,
  input  logic      intr_pulse,
  input  logic      halt_stb,
  input  logic      c1e_en,
  input  logic      vf_done,
  input  logic      pend_d,
  output lp_state_e state_d
);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_NORMAL: begin
        if (stopclk_req)   state_d = ST_STOPG;
        else if (halt_stb) state_d = fn_halt_target(c1e_en);
      end
      ST_HALT: begin
        if (intr_pulse) state_d = ST_NORMAL;
      end
      ST_XH_DOWN: begin
        if (vf_done) state_d = ST_XHALT;
      end
      ST_XHALT: begin
        if (intr_pulse) state_d = ST_XH_UP;
      end
      ST_XH_UP: begin
        if (vf_done) state_d = ST_NORMAL;
      end
      ST_STOPG: begin
        if (sleep_req)                      state_d = ST_SLEEP;
        else if (snoop_start || intr_pulse) state_d = ST_SNOOP;
        else if (!stopclk_req)              state_d = ST_NORMAL;
      end
      ST_SNOOP: begin
        state_d = pend_d ? ST_SNOOP : ST_STOPG;
      end
      ST_SLEEP: begin
        if (!sleep_req) state_d = ST_STOPG;
      end
      default: state_d = ST_NORMAL;
    endcase
  end

endmodule

// File: rtl/lp_state_ctrl.sv
module lp_state_ctrl
  import lp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stopclk_req,
  input  logic            sleep_req,
  input  logic            snoop_start,
  input  logic            snoop_done,
  input  logic            intr_pulse,
  input  logic            halt_stb,
  input  logic            c1e_en,
  input  logic            vf_done,
  output logic [ST_W-1:0] state_o,
  output logic            snoop_resp_o,
  output logic            intr_latched_o,
  output logic            vf_lower_o,
  output logic            vf_restore_o,
  output logic            violation_o
);

  lp_state_e state_q;
  lp_state_e state_d;
  logic      pend_d;
  logic      ev_bad_sleep;
  logic      ev_bad_wake;

  lp_event_flags u_flags (
    .clk            (clk),
    .rst_n          (rst_n),
    .state_q        (state_q),
    .sleep_req      (sleep_req),
    .snoop_start    (snoop_start),
    .snoop_done     (snoop_done),
    .intr_pulse     (intr_pulse),
    .pend_d         (pend_d),
    .intr_latched_q (intr_latched_o),
    .violation_q    (violation_o),
    .ev_bad_sleep   (ev_bad_sleep),
    .ev_bad_wake    (ev_bad_wake)
  );

  lp_next_state u_next (
    .state_q     (state_q),
    .stopclk_req (stopclk_req),
    .sleep_req   (sleep_req),
    .snoop_start (snoop_start),
    .intr_pulse  (intr_pulse),
    .halt_stb    (halt_stb),
    .c1e_en      (c1e_en),
    .vf_done     (vf_done),
    .pend_d      (pend_d),
    .state_d     (state_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_NORMAL;
    else        state_q <= state_d;
  end

  assign state_o      = state_q;
  assign snoop_resp_o = (state_q != ST_SLEEP);
  assign vf_lower_o   = (state_q == ST_XH_DOWN);
  assign vf_restore_o = (state_q == ST_XH_UP);

  p_xhalt_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_XHALT) |-> ($past(state_q) == ST_XH_DOWN) || ($past(state_q) == ST_XHALT));

  p_xh_down_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_XH_DOWN) && !vf_done |=> (state_q == ST_XH_DOWN));

  p_sleep_only_stopg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLEEP) && ($past(state_q) != ST_SLEEP) |-> ($past(state_q) == ST_STOPG));

  p_sleep_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLEEP) && sleep_req |=> (state_q == ST_SLEEP));

  p_bad_wake_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bad_wake |=> violation_o);

  p_bad_sleep_nostate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bad_sleep |=> (state_q != ST_SLEEP));

  p_snoop_return_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SNOOP) |=> (state_q == ST_SNOOP) || (state_q == ST_STOPG));

endmodule

// File: tb/lp_state_ctrl_tb_top.sv
module lp_state_ctrl_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stopclk_req = 0, sleep_req = 0, snoop_start = 0, snoop_done = 0;
  logic intr_pulse = 0, halt_stb = 0, c1e_en = 0, vf_done = 0;
  logic [2:0] state_o;
  logic snoop_resp_o, intr_latched_o, vf_lower_o, vf_restore_o, violation_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit cmp_on = 0;

  always #2 clk = ~clk;

  lp_state_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .stopclk_req(stopclk_req), .sleep_req(sleep_req),
    .snoop_start(snoop_start), .snoop_done(snoop_done), .intr_pulse(intr_pulse),
    .halt_stb(halt_stb), .c1e_en(c1e_en), .vf_done(vf_done),
    .state_o(state_o), .snoop_resp_o(snoop_resp_o), .intr_latched_o(intr_latched_o),
    .vf_lower_o(vf_lower_o), .vf_restore_o(vf_restore_o), .violation_o(violation_o)
  );

  // Behavioural reference: integer state, flags, pending-snoop count
  int m_st = 0;
  int m_pend = 0;
  bit m_il = 0, m_v = 0;

  always @(posedge clk) begin
    int nx; int np; bit nil; bit nv;
    if (!rst_n) begin
      m_st = 0; m_pend = 0; m_il = 0; m_v = 0;
    end else begin
      nx = m_st; np = 0; nv = m_v;
      nil = (m_st == 0) ? 1'b0 : m_il;
      if (sleep_req && !(m_st == 5 || m_st == 7)) nv = 1;
      if (m_st == 7 && (snoop_start || intr_pulse)) nv = 1;
      if (intr_pulse && (m_st == 1 || m_st == 3 || m_st == 5 || m_st == 6)) nil = 1;
      if (m_st == 0) begin
        if (stopclk_req) nx = 5;
        else if (halt_stb) nx = c1e_en ? 2 : 1;
      end else if (m_st == 1) begin
        if (intr_pulse) nx = 0;
      end else if (m_st == 2) begin
        if (vf_done) nx = 3;
      end else if (m_st == 3) begin
        if (intr_pulse) nx = 4;
      end else if (m_st == 4) begin
        if (vf_done) nx = 0;
      end else if (m_st == 5) begin
        if (sleep_req) nx = 7;
        else begin
          if (snoop_start) np = 1;
          if (snoop_start || intr_pulse) nx = 6;
          else if (!stopclk_req) nx = 0;
        end
      end else if (m_st == 6) begin
        np = ((m_pend != 0) && !snoop_done) || snoop_start;
        nx = (np != 0) ? 6 : 5;
      end else begin
        if (!sleep_req) nx = 5;
      end
      m_st = nx; m_pend = np; m_il = nil; m_v = nv;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      n_cmp++;
      if (state_o !== 3'(m_st) || intr_latched_o !== m_il || violation_o !== m_v ||
          snoop_resp_o !== (m_st != 7) || vf_lower_o !== (m_st == 2) ||
          vf_restore_o !== (m_st == 4)) begin
        n_bad++;
        $display("FAIL lockstep R1-model t=%0t: state %0d il %0b v %0b exp state %0d il %0b v %0b",
                 $time, state_o, intr_latched_o, violation_o, m_st, m_il, m_v);
      end
    end
  end

  task automatic step(input logic stp, input logic slp, input logic sn, input logic sd,
                      input logic irq, input logic hlt, input logic c1e, input logic vfd);
    @(negedge clk);
    stopclk_req = stp; sleep_req = slp; snoop_start = sn; snoop_done = sd;
    intr_pulse = irq; halt_stb = hlt; c1e_en = c1e; vf_done = vfd;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog: got hung expected done");
    finish_run();
  end

  initial begin
    rst_n = 0;
    step(0,0,0,0,0,0,0,0);
    cmp_on = 1;
    step(0,0,0,0,0,0,0,0);
    step(0,0,0,0,0,0,0,0);
    chk("R1", "state", state_o, 0);
    chk("R1", "intr_latched", intr_latched_o, 0);
    chk("R1", "violation", violation_o, 0);
    chk("R1", "snoop_resp", snoop_resp_o, 1);
    rst_n = 1;

    step(0,0,0,0,0,1,0,0); chk("R2", "plain halt", state_o, 1);
    step(0,0,0,0,0,0,0,0); chk("R4", "halt holds", state_o, 1);
    step(0,0,0,0,1,0,0,0); chk("R4", "halt wake", state_o, 0);
    chk("R10", "latched on halt wake", intr_latched_o, 1);
    step(0,0,0,0,0,0,0,0); chk("R10", "cleared after Normal", intr_latched_o, 0);

    step(0,0,0,0,0,1,1,0); chk("R2", "ext halt entry", state_o, 2);
    chk("R3", "lower request", vf_lower_o, 1);
    step(0,0,0,0,0,0,1,0); chk("R3", "waits vf_done", state_o, 2);
    step(0,0,0,0,0,0,1,1); chk("R3", "enters ext halt", state_o, 3);
    step(0,0,0,0,1,0,1,0); chk("R4", "ext halt exit", state_o, 4);
    chk("R4", "restore request", vf_restore_o, 1);
    step(0,0,0,0,0,0,1,0); chk("R4", "exit waits", state_o, 4);
    step(0,0,0,0,0,0,1,1); chk("R4", "back to Normal", state_o, 0);

    step(1,0,0,0,0,1,0,0); chk("R2", "stopclk beats halt", state_o, 5);
    step(1,0,1,0,0,0,0,0); chk("R5", "snoop detour", state_o, 6);
    step(1,0,0,0,0,0,0,0); chk("R5", "snoop pending", state_o, 6);
    step(1,0,0,1,0,0,0,0); chk("R5", "snoop serviced", state_o, 5);
    step(1,0,0,0,1,0,0,0); chk("R5", "intr detour", state_o, 6);
    chk("R10", "latched in stop-grant", intr_latched_o, 1);
    step(1,0,0,0,0,0,0,0); chk("R5", "intr one cycle", state_o, 5);

    step(1,1,1,0,0,0,0,0); chk("R6", "one-cycle sleep wins", state_o, 7);
    chk("R8", "no snoop response", snoop_resp_o, 0);
    step(1,1,1,0,0,0,0,0); chk("R8", "snoop in sleep holds", state_o, 7);
    chk("R8", "snoop in sleep violation", violation_o, 1);
    step(1,0,0,0,0,0,0,0); chk("R6", "sleep release", state_o, 5);
    step(0,0,0,0,0,0,0,0); chk("R6", "stopclk release", state_o, 0);

    rst_n = 0; step(0,0,0,0,0,0,0,0); rst_n = 1;
    chk("R1", "violation cleared", violation_o, 0);
    step(0,1,0,0,0,0,0,0); chk("R7", "sleep in Normal ignored", state_o, 0);
    chk("R7", "sleep in Normal flagged", violation_o, 1);
    step(0,0,0,0,0,0,0,0); chk("R7", "flag sticky", violation_o, 1);

    rst_n = 0; step(0,0,0,0,0,0,0,0); rst_n = 1;
    step(1,0,0,0,0,0,0,0); chk("R6", "to stop-grant", state_o, 5);
    step(1,1,0,0,0,0,0,0); chk("R6", "to sleep", state_o, 7);
    step(1,1,0,0,1,0,0,0); chk("R8", "intr in sleep holds", state_o, 7);
    chk("R8", "intr in sleep not latched", intr_latched_o, 0);
    rst_n = 0;
    step(1,1,0,0,0,0,0,0); chk("R9", "reset from sleep", state_o, 0);
    chk("R9", "violation cleared", violation_o, 0);
    rst_n = 1;
    step(0,0,0,0,0,0,0,0); chk("R9", "stays Normal", state_o, 0);

    step(0,0,0,0,0,0,0,0);
    finish_run();
  end

endmodule